// File: doc/BRIEF.md
# Add/Subtract Unit with Status and Control Flags

This block adds or subtracts two integer operands, either across the full 16-bit word or only across the low byte. It returns the registered result together with a 16-bit flag word. Six status bits in that word describe the last operation: carry/borrow, even parity of the low byte, nibble carry/borrow, zero, sign and signed overflow. Three control bits (trap, interrupt enable, direction) sit in the same word. Dedicated set and clear inputs drive them, and arithmetic never changes them.

A caller presents the operands, the operation code and the width select with `op_valid` high for one clock. The result and the refreshed status bits appear after that edge. The status bits and the result keep their values until the next valid operation. In byte mode the upper byte of the result copies the upper byte of operand A unchanged.

Top module: `addsub_flags_unit`

## Requirements
- R1: After reset, `result_o` and `flags_o` both read 0x0000.
- R2: On a clock edge with `op_valid` high, `result_o` becomes A+B (`op_code`=0) or A-B (`op_code`=1), modulo 2^16 in word mode (`byte_mode`=0). In byte mode bits 7:0 take the 8-bit sum or difference of the low bytes, and bits 15:8 take A[15:8].
- R3: Flag bit 0 (carry) is set on an add that carries out of the top bit of the active width (bit 15 in word mode, bit 7 in byte mode), and on a subtract whose unsigned minuend is smaller than the subtrahend in that width.
- R4: Flag bit 6 (zero) is set exactly when the active width of the result is all zeros. Flag bit 7 (sign) equals the top bit of the active width of the result.
- R5: Flag bit 11 (overflow) is set when the two's-complement result does not fit the active width.
- R6: Flag bit 4 (auxiliary) is set on a carry out of bit 3 on an add, or on a borrow into bit 3 on a subtract (A[3:0] < B[3:0]), in either width.
- R7: Flag bit 2 (parity) is set when result bits 7:0 hold an even number of ones, in either width.
- R8: On an edge with `op_valid` low, `result_o` and the six status bits keep their values.
- R9: Bits 8 (trap), 9 (interrupt enable) and 10 (direction) are set by their `*_set` input and cleared by their `*_clr` input on a clock edge. Clear wins when both are high. They hold otherwise, and ALU operations never change them.
- R10: Flag word bits 1, 3, 5 and 12 to 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Perform an operation on this edge |
| op_code | input | 1 | 0 = add, 1 = subtract |
| byte_mode | input | 1 | 1 = operate on low byte, 0 = full word |
| opnd_a | input | 16 | First operand (minuend) |
| opnd_b | input | 16 | Second operand (subtrahend) |
| dir_set | input | 1 | Set direction bit |
| dir_clr | input | 1 | Clear direction bit |
| ie_set | input | 1 | Set interrupt-enable bit |
| ie_clr | input | 1 | Clear interrupt-enable bit |
| trap_set | input | 1 | Set trap bit |
| trap_clr | input | 1 | Clear trap bit |
| result_o | output | 16 | Registered result |
| flags_o | output | 16 | Flag word |

## Verification
An arithmetic operation can share a clock edge with a control-flag command. Both then write into the same flag register, each on its own bits. The bench provokes this by pulsing random set and clear inputs, sometimes both for one bit, in the same cycles as random byte and word operations. After each edge it compares every status field and every control bit against a model, which confirms that neither update disturbs the other and that clear wins a set/clear tie.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    localparam int FLAG_W  = 16;
    localparam int CF_POS  = 0;
    localparam int PF_POS  = 2;
    localparam int AF_POS  = 4;
    localparam int ZF_POS  = 6;
    localparam int SF_POS  = 7;
    localparam int TF_POS  = 8;
    localparam int IF_POS  = 9;
    localparam int DF_POS  = 10;
    localparam int OF_POS  = 11;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic ovf;
    } status_t;

    typedef struct packed {
        logic trap;
        logic ien;
        logic dir;
    } ctrl_t;

    function automatic logic [FLAG_W-1:0] pack_flags(status_t s, ctrl_t c);
        logic [FLAG_W-1:0] w;
        w = '0;
        w[CF_POS] = s.cf;
        w[PF_POS] = s.pf;
        w[AF_POS] = s.af;
        w[ZF_POS] = s.zf;
        w[SF_POS] = s.sf;
        w[OF_POS] = s.ovf;
        w[TF_POS] = c.trap;
        w[IF_POS] = c.ien;
        w[DF_POS] = c.dir;
        return w;
    endfunction

endpackage

// File: rtl/addsub_core.sv
module addsub_core
    import addsub_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              sub_i,
    input  logic              byte_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output status_t           stat_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int NIB_W  = 4;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum_word;
    logic [HALF_W:0]   sum_byte;
    logic [NIB_W:0]    sum_nib;
    logic              a_top, b_top, r_top;

    always_comb begin
        b_eff    = sub_i ? ~b_i : b_i;
        sum_word = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
        sum_byte = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, sub_i};
        sum_nib  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, sub_i};

        if (byte_i) begin
            res_o     = {a_i[DATA_W-1:HALF_W], sum_byte[HALF_W-1:0]};
            stat_o.cf = sum_byte[HALF_W] ^ sub_i;
            stat_o.zf = (sum_byte[HALF_W-1:0] == '0);
            a_top     = a_i[HALF_W-1];
            b_top     = b_eff[HALF_W-1];
            r_top     = sum_byte[HALF_W-1];
        end else begin
            res_o     = sum_word[DATA_W-1:0];
            stat_o.cf = sum_word[DATA_W] ^ sub_i;
            stat_o.zf = (sum_word[DATA_W-1:0] == '0);
            a_top     = a_i[DATA_W-1];
            b_top     = b_eff[DATA_W-1];
            r_top     = sum_word[DATA_W-1];
        end
        stat_o.sf  = r_top;
        stat_o.ovf = (a_top == b_top) && (r_top != a_top);
        stat_o.af  = sum_nib[NIB_W] ^ sub_i;
        stat_o.pf  = ~^res_o[7:0];
    end

endmodule

// File: rtl/flag_word_reg.sv
module flag_word_reg
    import addsub_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] res_i,
    input  status_t           stat_i,
    input  ctrl_t             set_i,
    input  ctrl_t             clr_i,
    output logic [DATA_W-1:0] res_o,
    output logic [FLAG_W-1:0] flags_o
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        status_t           stat;
        ctrl_t             ctrl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.res  = res_i;
            st_d.stat = stat_i;
        end
        st_d.ctrl = (st_q.ctrl | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o   = st_q.res;
    assign flags_o = pack_flags(st_q.stat, st_q.ctrl);

    // R8
    hold_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(res_o) && $stable(flags_o[OF_POS]) && $stable(flags_o[SF_POS:ZF_POS])
                     && $stable(flags_o[AF_POS]) && $stable(flags_o[PF_POS]) && $stable(flags_o[CF_POS])));

    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(flags_o[DF_POS:TF_POS]));

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i.dir |=> !flags_o[DF_POS]);

endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit
    import addsub_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_code,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              dir_set,
    input  logic              dir_clr,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              trap_set,
    input  logic              trap_clr,
    output logic [DATA_W-1:0] result_o,
    output logic [FLAG_W-1:0] flags_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] core_res;
    status_t           core_stat;
    ctrl_t             set_v, clr_v;

    assign set_v = '{trap: trap_set, ien: ie_set, dir: dir_set};
    assign clr_v = '{trap: trap_clr, ien: ie_clr, dir: dir_clr};

    addsub_core #(.DATA_W(DATA_W)) u_core (
        .sub_i  (op_code),
        .byte_i (byte_mode),
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .res_o  (core_res),
        .stat_o (core_stat)
    );

    flag_word_reg #(.DATA_W(DATA_W)) u_freg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (op_valid),
        .res_i   (core_res),
        .stat_i  (core_stat),
        .set_i   (set_v),
        .clr_i   (clr_v),
        .res_o   (result_o),
        .flags_o (flags_o)
    );

    // R4
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> flags_o[ZF_POS] ==
            ($past(byte_mode) ? (result_o[HALF_W-1:0] == '0) : (result_o == '0)));

    // R4
    sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> flags_o[SF_POS] ==
            ($past(byte_mode) ? result_o[HALF_W-1] : result_o[DATA_W-1]));

    // R2
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && byte_mode) |=> result_o[DATA_W-1:HALF_W] == $past(opnd_a[DATA_W-1:HALF_W]));

endmodule

// File: tb/sim_addsub_flags_unit.sv
module sim_addsub_flags_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 0, op_code = 0, byte_mode = 0;
    logic [15:0] opnd_a = 0, opnd_b = 0;
    logic        dir_set = 0, dir_clr = 0, ie_set = 0, ie_clr = 0, trap_set = 0, trap_clr = 0;
    logic [15:0] result_o, flags_o;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [15:0] exp_res = 0;
    logic [15:0] exp_flg = 0;

    always #10 clk = ~clk;

    addsub_flags_unit u0 (.*);

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(logic [15:0] a, logic [15:0] b, logic s, logic bm);
        logic [16:0] w; logic [15:0] r, f; int ones;
        logic ta, tb_, tr;
        f = 0;
        if (bm) begin
            w = s ? ({9'd0, a[7:0]} - {9'd0, b[7:0]}) : ({9'd0, a[7:0]} + {9'd0, b[7:0]});
            r = {a[15:8], w[7:0]};
            f[0] = s ? (a[7:0] < b[7:0]) : w[8];
            f[6] = (r[7:0] == 0);
            ta = a[7]; tb_ = b[7]; tr = r[7];
        end else begin
            w = s ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
            r = w[15:0];
            f[0] = s ? (a < b) : w[16];
            f[6] = (r == 0);
            ta = a[15]; tb_ = b[15]; tr = r[15];
        end
        f[7]  = tr;
        f[11] = s ? ((ta != tb_) && (tr != ta)) : ((ta == tb_) && (tr != ta));
        f[4]  = s ? (a[3:0] < b[3:0]) : (({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15);
        ones = $countones(r[7:0]);
        f[2]  = (ones % 2 == 0);
        return {r, f};
    endfunction

    task automatic step(logic v, logic s, logic bm, logic [15:0] a, logic [15:0] b, logic [5:0] cs);
        logic [31:0] m;
        @(negedge clk);
        op_valid = v; op_code = s; byte_mode = bm; opnd_a = a; opnd_b = b;
        {dir_set, dir_clr, ie_set, ie_clr, trap_set, trap_clr} = cs;
        if (v) begin
            m = model(a, b, s, bm);
            exp_res = m[31:16];
            exp_flg = (exp_flg & 16'h0700) | m[15:0];
        end
        if (dir_set) exp_flg[10] = 1; if (dir_clr) exp_flg[10] = 0;
        if (ie_set)  exp_flg[9]  = 1; if (ie_clr)  exp_flg[9]  = 0;
        if (trap_set) exp_flg[8] = 1; if (trap_clr) exp_flg[8] = 0;
        @(negedge clk);
        op_valid = 0; {dir_set, dir_clr, ie_set, ie_clr, trap_set, trap_clr} = 0;
        chk(v ? "R2 result" : "R8 result hold", result_o, exp_res);
        chk(v ? "R3 carry" : "R8 carry hold", {15'd0, flags_o[0]}, {15'd0, exp_flg[0]});
        chk(v ? "R4 zero/sign" : "R8 zero/sign hold", {14'd0, flags_o[7:6]}, {14'd0, exp_flg[7:6]});
        chk(v ? "R5 overflow" : "R8 overflow hold", {15'd0, flags_o[11]}, {15'd0, exp_flg[11]});
        chk(v ? "R6 aux" : "R8 aux hold", {15'd0, flags_o[4]}, {15'd0, exp_flg[4]});
        chk(v ? "R7 parity" : "R8 parity hold", {15'd0, flags_o[2]}, {15'd0, exp_flg[2]});
        chk("R9 control bits", {13'd0, flags_o[10:8]}, {13'd0, exp_flg[10:8]});
        chk("R10 unused bits", flags_o & 16'hF02A, 16'h0000);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset result", result_o, 16'h0000);
        chk("R1 reset flags", flags_o, 16'h0000);
        rst_n = 1'b1;
        // directed corners
        step(1, 0, 0, 16'hFFFF, 16'h0001, 6'b0);   // R3 carry, zero, no overflow
        step(1, 1, 0, 16'h0000, 16'h0001, 6'b0);   // R3 borrow
        step(1, 0, 0, 16'h7FFF, 16'h0001, 6'b0);   // R4 sign, R5 overflow
        step(1, 1, 0, 16'h8000, 16'h0001, 6'b0);   // R5 sub overflow
        step(1, 0, 1, 16'h23FF, 16'h0001, 6'b0);   // byte carry from bit 7
        step(1, 1, 0, 16'h2300, 16'h0001, 6'b0);   // word borrow clear, R6 aux borrow
        step(1, 0, 1, 16'h007F, 16'h0001, 6'b0);   // byte overflow
        step(0, 1, 0, 16'h1234, 16'h5678, 6'b0);   // R8 hold
        step(1, 0, 0, 16'h0008, 16'h0008, 6'b101010); // R9 all set with op
        step(0, 0, 0, 16'h0000, 16'h0000, 6'b110000); // R9 dir set+clr, clear wins
        step(1, 1, 1, 16'hAB10, 16'h0020, 6'b000101); // R9 ie,trap clear with op
        // random
        for (int i = 0; i < 400; i++) begin
            logic [5:0] cs;
            cs = ($urandom % 4 == 0) ? 6'($urandom) : 6'd0;
            step(($urandom % 5) != 0, 1'($urandom), 1'($urandom),
                 16'($urandom), 16'($urandom), cs);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule